// File: doc/BRIEF.md
# Vector Multiply-Long Unit with Carry-Less Forms

This block takes one 32-bit instruction word from the multiply-long encoding group, together with two source vectors. It decodes the word and returns a vector of widened products one clock later. Each source vector is viewed as a row of double-width elements. The narrow operand of each lane is read from either the low half or the high half of that element, so both operands of a lane come from the same position in their vectors.

Two kinds of product are supported. Integer forms multiply signed or unsigned values and can produce 16-, 32- or 64-bit lane results. Polynomial forms multiply over GF(2), where partial products are combined with XOR and carries are discarded. They produce 16-bit results from 8-bit inputs, or 32-bit results from 16-bit inputs. The polynomial forms are recognised by an all-ones size field and are checked before the integer forms.

Alongside the product, the unit reports which form matched, the result element size and three 4-bit register numbers for a register file outside the block. It also flags words that are undefined.

Top module: `vmull_unit`

## Requirements
- R1: A word is undefined unless bits 31:29 = 111, bits 27:23 = 11100, bit 16 = 1, bits 11:8 = 1110 and bits 6, 4 and 0 are all 0. For an undefined word the unit outputs `out_undef` = 1, `out_form` = 0, `out_esize` = 0 and a result of zero.
- R2: The register numbers are built as follows: destination = {bit 22, bits 15:13}, first source = {bit 7, bits 19:17}, second source = {bit 5, bits 3:1}. These are output for every accepted word. A register number of 8 or more (bit 22, 7 or 5 set) makes the word undefined, with the outputs given in R1.
- R3: When bits 21:20 = 11, the word is a polynomial multiply with `out_form` = 3. Bit 28 = 0 selects 8x8->16 with `out_esize` = 1. Bit 28 = 1 selects 16x16->32 with `out_esize` = 2.
- R4: For a polynomial form, each result lane is the carry-less product of its two narrow operands. As a result, the most significant bit of every lane is zero.
- R5: Bit 12 = 0 takes each lane's operands from the low half of the double-width element, and bit 12 = 1 takes them from the high half. The other half has no effect on the result.
- R6: When bits 21:20 are 00, 01 or 10, the word is an integer multiply-long. The input halves are 8, 16 or 32 bits wide, and `out_esize` = size + 1. Bit 28 = 0 gives a signed product with `out_form` = 1. Bit 28 = 1 gives an unsigned product with `out_form` = 2. The result is the full-width product.
- R7: `out_valid` is `in_valid` delayed by exactly one clock. Cycles with `in_valid` low leave every other output unchanged.
- R8: While reset is asserted (`rst_n` = 0), every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction and operands are present this cycle |
| in_instr | input | 32 | Instruction word |
| src_n | input | VEC_W | First source vector |
| src_m | input | VEC_W | Second source vector |
| out_valid | output | 1 | Registered result is new this cycle |
| out_undef | output | 1 | Word was undefined |
| out_form | output | 2 | 0 none, 1 signed, 2 unsigned, 3 polynomial |
| out_esize | output | 2 | Result lane size: 0 none, 1 16-bit, 2 32-bit, 3 64-bit |
| out_qd | output | 4 | Destination register number |
| out_qn | output | 4 | First source register number |
| out_qm | output | 4 | Second source register number |
| out_result | output | VEC_W | Widened products |

## Verification
The bench instantiates the unit with `VEC_W` = 64. At this width a vector holds four 16-bit lanes, so every one of the 65,536 pairs of 8-bit polynomial operands can be applied in both bottom and top positions within a short run. In each case the unused half carries the inverse of the used half, which makes any leak from the wrong half visible. The 16-bit polynomial and all integer sizes are covered with pseudo-random operands plus all-ones and sign-boundary values. Every fixed bit of the encoding is flipped on its own, and each register-number high bit is set on its own.

// File: rtl/vmull_pkg.sv
package vmull_pkg;

    typedef enum logic [1:0] {
        FORM_NONE = 2'd0,
        FORM_SINT = 2'd1,
        FORM_UINT = 2'd2,
        FORM_POLY = 2'd3
    } vm_form_e;

    typedef enum logic [1:0] {
        ESZ_NONE = 2'd0,
        ESZ_16   = 2'd1,
        ESZ_32   = 2'd2,
        ESZ_64   = 2'd3
    } vm_esize_e;

    typedef struct packed {
        logic      undef;
        vm_form_e  form;
        vm_esize_e esize;
        logic      top;
        logic [3:0] qd;
        logic [3:0] qn;
        logic [3:0] qm;
    } vm_dec_t;

endpackage

// File: rtl/vmull_decode.sv
module vmull_decode
    import vmull_pkg::*;
(
    input  logic [31:0] instr,
    output vm_dec_t     dec
);
    logic       fixed_ok;
    logic       big_reg;
    logic [1:0] size;

    always_comb begin
        fixed_ok = (instr[31:29] == 3'b111) && (instr[27:23] == 5'b11100) &&
                   instr[16] && (instr[11:8] == 4'b1110) &&
                   !instr[6] && !instr[4] && !instr[0];
        big_reg  = instr[22] | instr[7] | instr[5];
        size     = instr[21:20];

        dec.qd    = {instr[22], instr[15:13]};
        dec.qn    = {instr[7],  instr[19:17]};
        dec.qm    = {instr[5],  instr[3:1]};
        dec.top   = instr[12];
        dec.undef = !fixed_ok || big_reg;
        dec.form  = FORM_NONE;
        dec.esize = ESZ_NONE;

        if (!dec.undef) begin
            if (size == 2'b11) begin
                // polynomial forms win over the integer forms
                dec.form  = FORM_POLY;
                dec.esize = instr[28] ? ESZ_32 : ESZ_16;
            end else begin
                dec.form = instr[28] ? FORM_UINT : FORM_SINT;
                case (size)
                    2'b00:   dec.esize = ESZ_16;
                    2'b01:   dec.esize = ESZ_32;
                    default: dec.esize = ESZ_64;
                endcase
            end
        end
    end
endmodule

// File: rtl/vmull_lane.sv
module vmull_lane
    import vmull_pkg::*;
#(
    parameter int HW = 8
) (
    input  logic [HW-1:0]   a,
    input  logic [HW-1:0]   b,
    input  vm_form_e        form,
    output logic [2*HW-1:0] prod
);
    localparam int EW = 2 * HW;

    logic [EW-1:0] ext_a_s, ext_b_s;
    logic [EW-1:0] ext_a_u, ext_b_u;
    logic [EW-1:0] p_sint, p_uint, p_poly;

    always_comb begin
        ext_a_s = {{HW{a[HW-1]}}, a};
        ext_b_s = {{HW{b[HW-1]}}, b};
        ext_a_u = {{HW{1'b0}}, a};
        ext_b_u = {{HW{1'b0}}, b};
        p_sint  = ext_a_s * ext_b_s;
        p_uint  = ext_a_u * ext_b_u;
        p_poly  = '0;
        for (int k = 0; k < HW; k++) begin
            if (b[k]) p_poly = p_poly ^ (ext_a_u << k);
        end
        case (form)
            FORM_SINT: prod = p_sint;
            FORM_UINT: prod = p_uint;
            FORM_POLY: prod = p_poly;
            default:   prod = '0;
        endcase
    end
endmodule

// File: rtl/vmull_group.sv
module vmull_group
    import vmull_pkg::*;
#(
    parameter int VEC_W = 128,
    parameter int HW    = 8
) (
    input  logic [VEC_W-1:0] src_n,
    input  logic [VEC_W-1:0] src_m,
    input  logic             top,
    input  vm_form_e         form,
    output logic [VEC_W-1:0] res
);
    localparam int EW    = 2 * HW;
    localparam int LANES = VEC_W / EW;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [HW-1:0] op_a, op_b;
        assign op_a = top ? src_n[l*EW+HW +: HW] : src_n[l*EW +: HW];
        assign op_b = top ? src_m[l*EW+HW +: HW] : src_m[l*EW +: HW];
        vmull_lane #(.HW(HW)) u_lane (
            .a    (op_a),
            .b    (op_b),
            .form (form),
            .prod (res[l*EW +: EW])
        );
    end
endmodule

// File: rtl/vmull_unit.sv
module vmull_unit
    import vmull_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [31:0]      in_instr,
    input  logic [VEC_W-1:0] src_n,
    input  logic [VEC_W-1:0] src_m,
    output logic             out_valid,
    output logic             out_undef,
    output logic [1:0]       out_form,
    output logic [1:0]       out_esize,
    output logic [3:0]       out_qd,
    output logic [3:0]       out_qn,
    output logic [3:0]       out_qm,
    output logic [VEC_W-1:0] out_result
);
    localparam int NGRP = 3;

    typedef struct packed {
        logic             valid;
        logic             undef;
        vm_form_e         form;
        vm_esize_e        esize;
        logic [3:0]       qd;
        logic [3:0]       qn;
        logic [3:0]       qm;
        logic [VEC_W-1:0] res;
    } st_t;

    st_t     st_d, st_q;
    vm_dec_t dec;
    logic [VEC_W-1:0] grp_res [NGRP];

    vmull_decode u_dec (
        .instr (in_instr),
        .dec   (dec)
    );

    // one datapath per input half-width: 8, 16 and 32 bits
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        vmull_group #(.VEC_W(VEC_W), .HW(8 << g)) u_grp (
            .src_n (src_n),
            .src_m (src_m),
            .top   (dec.top),
            .form  (dec.form),
            .res   (grp_res[g])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.undef = dec.undef;
            st_d.form  = dec.form;
            st_d.esize = dec.esize;
            st_d.qd    = dec.qd;
            st_d.qn    = dec.qn;
            st_d.qm    = dec.qm;
            case (dec.esize)
                ESZ_16:  st_d.res = grp_res[0];
                ESZ_32:  st_d.res = grp_res[1];
                ESZ_64:  st_d.res = grp_res[2];
                default: st_d.res = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.valid;
    assign out_undef  = st_q.undef;
    assign out_form   = st_q.form;
    assign out_esize  = st_q.esize;
    assign out_qd     = st_q.qd;
    assign out_qn     = st_q.qn;
    assign out_qm     = st_q.qm;
    assign out_result = st_q.res;
endmodule

// File: rtl/vmull_unit_chk.sv
module vmull_unit_chk #(
    parameter int VEC_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [31:0]      in_instr,
    input logic             out_valid,
    input logic             out_undef,
    input logic [1:0]       out_form,
    input logic [1:0]       out_esize,
    input logic [VEC_W-1:0] out_result
);
    logic msb16_any, msb32_any;

    always_comb begin
        msb16_any = 1'b0;
        msb32_any = 1'b0;
        for (int l = 0; l < VEC_W / 16; l++) msb16_any = msb16_any | out_result[l*16+15];
        for (int l = 0; l < VEC_W / 32; l++) msb32_any = msb32_any | out_result[l*32+31];
    end

    p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_result) && $stable(out_form) && $stable(out_esize)));
    p_undef_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_undef) |-> (out_form == 2'd0 && out_esize == 2'd0 && out_result == '0));
    p_bigreg_undef_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_instr[22] || in_instr[7] || in_instr[5])) |=> out_undef);
    p_poly_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_form == 2'd3) |-> (out_esize == 2'd1 || out_esize == 2'd2));
    p_poly_msb16_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_form == 2'd3 && out_esize == 2'd1) |-> !msb16_any);
    p_poly_msb32_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_form == 2'd3 && out_esize == 2'd2) |-> !msb32_any);
    p_int_size_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_form == 2'd1 || out_form == 2'd2)) |-> out_esize != 2'd0);
endmodule

bind vmull_unit vmull_unit_chk #(.VEC_W(VEC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_instr   (in_instr),
    .out_valid  (out_valid),
    .out_undef  (out_undef),
    .out_form   (out_form),
    .out_esize  (out_esize),
    .out_result (out_result)
);

// File: tb/vmull_unit_tb.sv
`timescale 1ns/1ps
module vmull_unit_tb;
    localparam int W = 64;
    localparam logic [31:0] FIXMASK = 32'hEF810F51;
    localparam logic [31:0] FIXVAL  = 32'hEE010E00;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [31:0]   in_instr = '0;
    logic [W-1:0]  src_n = '0, src_m = '0;
    logic          out_valid, out_undef;
    logic [1:0]    out_form, out_esize;
    logic [3:0]    out_qd, out_qn, out_qm;
    logic [W-1:0]  out_result;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vmull_unit #(.VEC_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
        .src_n(src_n), .src_m(src_m), .out_valid(out_valid), .out_undef(out_undef),
        .out_form(out_form), .out_esize(out_esize), .out_qd(out_qd), .out_qn(out_qn),
        .out_qm(out_qm), .out_result(out_result)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit u, input logic [1:0] sz, input bit top,
                                       input logic [3:0] qd, qn, qm);
        return {3'b111, u, 5'b11100, qd[3], sz, qn[2:0], 1'b1, qd[2:0], top,
                4'b1110, qn[3], 1'b0, qm[3], 1'b0, qm[2:0], 1'b0};
    endfunction

    function automatic logic [63:0] ref_mul(input logic [31:0] ins, input logic [63:0] n, m);
        logic [63:0] r = '0;
        logic [1:0] sz = ins[21:20];
        bit poly = (sz == 2'b11);
        int hw = poly ? (ins[28] ? 16 : 8) : (8 << sz);
        int ew = 2 * hw;
        logic [63:0] hmask = (64'd1 << hw) - 1;
        logic [63:0] emask = (ew == 64) ? '1 : ((64'd1 << ew) - 1);
        for (int l = 0; l < 64 / ew; l++) begin
            int sh = l * ew + (ins[12] ? hw : 0);
            logic [63:0] a = (n >> sh) & hmask;
            logic [63:0] b = (m >> sh) & hmask;
            logic [63:0] p = '0;
            if (poly) begin
                for (int k = 0; k < hw; k++) if (b[k]) p = p ^ (a << k);
            end else if (!ins[28]) begin
                longint sa = longint'(a);
                longint sb = longint'(b);
                if (a[hw-1]) sa = sa - (longint'(1) << hw);
                if (b[hw-1]) sb = sb - (longint'(1) << hw);
                p = 64'(sa * sb);
            end else begin
                p = a * b;
            end
            r = r | ((p & emask) << (l * ew));
        end
        return r;
    endfunction

    // drive one accepted word, sample one cycle later
    task automatic run_op(input logic [31:0] ins, input logic [63:0] n, m, input string tag);
        bit undef = ((ins & FIXMASK) != FIXVAL) || ins[22] || ins[7] || ins[5];
        logic [1:0] ef, ee;
        logic [63:0] er;
        if (undef) begin
            ef = 2'd0; ee = 2'd0; er = '0;
        end else if (ins[21:20] == 2'b11) begin
            ef = 2'd3; ee = ins[28] ? 2'd2 : 2'd1; er = ref_mul(ins, n, m);
        end else begin
            ef = ins[28] ? 2'd2 : 2'd1; ee = ins[21:20] + 2'd1; er = ref_mul(ins, n, m);
        end
        @(negedge clk);
        in_valid = 1'b1; in_instr = ins; src_n = n; src_m = m;
        @(posedge clk); #1;
        chk(out_valid == 1'b1 && out_undef == undef, {tag, " valid/undef"},
            {62'd0, out_valid, out_undef}, {62'd0, 1'b1, undef});
        chk(out_form == ef && out_esize == ee, {tag, " form/esize"},
            {60'd0, out_form, out_esize}, {60'd0, ef, ee});
        chk(out_result == er, {tag, " result"}, out_result, er);
        chk(out_qd == {ins[22], ins[15:13]} && out_qn == {ins[7], ins[19:17]} &&
            out_qm == {ins[5], ins[3:1]}, "R2 register fields",
            {52'd0, out_qd, out_qn, out_qm},
            {52'd0, ins[22], ins[15:13], ins[7], ins[19:17], ins[5], ins[3:1]});
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] hold_res;
        repeat (3) @(posedge clk);
        #1;
        // R8: reset state
        chk(out_valid == 0 && out_undef == 0 && out_form == 0 && out_esize == 0 &&
            out_qd == 0 && out_qn == 0 && out_qm == 0 && out_result == 0,
            "R8 reset outputs", out_result, 64'd0);
        @(negedge clk); rst_n = 1'b1;

        // R3 R4 R5: exhaustive 8x8 polynomial, bottom and top, opposite half inverted
        for (int t = 0; t < 2; t++) begin
            for (int a = 0; a < 256; a++) begin
                for (int k = 0; k < 64; k++) begin
                    logic [63:0] n = '0, m = '0;
                    for (int l = 0; l < 4; l++) begin
                        logic [7:0] av = 8'(a), bv = 8'(4 * k + l);
                        n[l*16 +: 16] = t ? {av, ~av} : {~av, av};
                        m[l*16 +: 16] = t ? {bv, ~bv} : {~bv, bv};
                    end
                    run_op(mk(1'b0, 2'b11, t[0], 4'd1, 4'd2, 4'd3), n, m, "R3 R4 R5 poly8");
                end
            end
        end

        // R3 R4 R5: 16x16 polynomial, pseudo-random and all-ones
        run_op(mk(1'b1, 2'b11, 1'b0, 4'd0, 4'd0, 4'd0), '1, '1, "R4 poly16 ones bottom");
        run_op(mk(1'b1, 2'b11, 1'b1, 4'd7, 4'd7, 4'd7), '1, '1, "R4 poly16 ones top");
        for (int i = 0; i < 1000; i++) begin
            run_op(mk(1'b1, 2'b11, i[0], 3'(i), 3'(i + 1), 3'(i + 2)),
                   {$urandom, $urandom}, {$urandom, $urandom}, "R3 R4 R5 poly16");
        end

        // R5 R6: integer forms, all sizes, signedness and halves
        for (int s = 0; s < 3; s++) begin
            for (int u = 0; u < 2; u++) begin
                for (int t = 0; t < 2; t++) begin
                    logic [31:0] ins = mk(u[0], 2'(s), t[0], 4'd4, 4'd5, 4'd6);
                    run_op(ins, '1, '1, "R6 int ones");
                    run_op(ins, {4{16'h8080}}, {4{16'h8000}}, "R6 int sign edge");
                    run_op(ins, 64'h8000_0000_8000_0000, 64'h7FFF_FFFF_8000_0000, "R6 int min");
                    for (int i = 0; i < 300; i++)
                        run_op(ins, {$urandom, $urandom}, {$urandom, $urandom}, "R5 R6 int");
                end
            end
        end

        // R1: every fixed bit flipped alone
        for (int b = 0; b < 32; b++) begin
            if (FIXMASK[b])
                run_op(mk(1'b0, 2'b11, 1'b0, 4'd1, 4'd1, 4'd1) ^ (32'd1 << b), '1, '1, "R1 fixed bit");
        end
        // R2: high register bits
        run_op(mk(1'b0, 2'b00, 1'b0, 4'd8, 4'd0, 4'd0), '1, '1, "R2 qd high");
        run_op(mk(1'b1, 2'b11, 1'b0, 4'd0, 4'd9, 4'd0), '1, '1, "R2 qn high");
        run_op(mk(1'b0, 2'b10, 1'b1, 4'd0, 4'd0, 4'd15), '1, '1, "R2 qm high");

        // R7: idle cycle holds outputs
        run_op(mk(1'b0, 2'b11, 1'b0, 4'd2, 4'd3, 4'd4), 64'h1234, 64'h5678, "R7 setup");
        hold_res = out_result;
        @(negedge clk);
        in_valid = 1'b0; in_instr = mk(1'b1, 2'b01, 1'b1, 4'd5, 4'd6, 4'd7);
        src_n = '1; src_m = '1;
        @(posedge clk); #1;
        chk(out_valid == 0, "R7 valid drops", {63'd0, out_valid}, 64'd0);
        chk(out_result == hold_res && out_form == 2'd3 && out_qd == 4'd2,
            "R7 idle hold", out_result, hold_res);
        // R7: exact one-cycle latency
        @(negedge clk);
        in_valid = 1'b1; in_instr = mk(1'b1, 2'b00, 1'b0, 4'd1, 4'd1, 4'd1);
        src_n = 64'h0000_0000_0000_0003; src_m = 64'h0000_0000_0000_0005;
        #1;
        chk(out_valid == 0, "R7 not early", {63'd0, out_valid}, 64'd0);
        @(posedge clk); #1;
        chk(out_valid == 1 && out_result == 64'd15, "R7 on time", out_result, 64'd15);
        @(negedge clk); in_valid = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule